// File: doc/BRIEF.md
# Four-State Snooping Coherence Line Controller

This block keeps the coherence state of one private cache in a shared-bus multiprocessor. It holds a direct-mapped array of tags and line states (invalid, shared, exclusive-clean, modified), answers processor loads and stores against it, and starts bus transactions when a request cannot be served locally. These transactions are a plain read, a read-for-ownership, a data-less upgrade and a victim write-back. At the same time it watches the transactions of the other caches on the bus. It reports whether it holds a copy and whether that copy is dirty, and it demotes or drops its own lines in response.

A load that misses samples the combined shared line at grant. If no other cache claims the line, the line is filled as exclusive-clean, so a later store to it completes without any bus traffic. Each bus transaction is atomic: it takes effect in the cycle its grant arrives, so the state array never holds transient states. The processor holds its request until `cpu_ready`, and that handshake stalls it for as long as a bus transaction is pending. Line data, arbitration and replacement beyond direct mapping are outside this block.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After a synchronous active-low reset every line is invalid, so every access misses and every snoop reports `snp_shared` and `snp_dirty` low.
- R2: A load to a valid line with a matching tag completes in the same cycle with no bus request. A load miss requests `bus_cmd` 0 (read) at `bus_addr` = `cpu_addr`. At grant the line becomes shared if `bus_shared_in` is high and exclusive-clean if it is low, and `cpu_ready` rises in that grant cycle.
- R3: A store to a line that is absent or invalid requests `bus_cmd` 1 (read-for-ownership) at `cpu_addr`. At grant the line becomes modified and `cpu_ready` rises.
- R4: A store that hits an exclusive-clean or modified line completes in its request cycle, raises no bus request and leaves the line modified.
- R5: A store that hits a shared line requests `bus_cmd` 2 (upgrade). At grant the line becomes modified and `cpu_ready` rises.
- R6: While `snp_valid` is high, `snp_shared` is high exactly when a valid line with the snooped tag sits at the snooped index, and `snp_dirty` is high exactly when that line is modified. Both flags are combinational in the snoop cycle.
- R7: A snooped read (`snp_cmd` 0) turns a matching exclusive-clean or modified line into shared and leaves a shared line shared.
- R8: A snooped read-for-ownership (`snp_cmd` 1) or upgrade (`snp_cmd` 2) makes a matching line invalid. A modified line signals `snp_dirty` in that cycle so that it supplies the data.
- R9: A snooped write-back (`snp_cmd` 3) leaves every line unchanged.
- R10: A miss whose index holds a modified line with another tag first requests `bus_cmd` 3 (write-back) at the victim address {old tag, index}. That grant does not raise `cpu_ready` and leaves the victim invalid, and the fill follows. An exclusive-clean or shared victim is replaced with no write-back.
- R11: In a cycle with `snp_valid` high the processor request neither completes nor changes any line; the snoop is applied and the request is evaluated again in the next cycle. `bus_gnt` is never high together with `snp_valid`.
- R12: The bus command is decided from the line state in the current cycle. If a snoop invalidates a shared line while its upgrade waits for grant, the pending request becomes a read-for-ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Line address; low INDEX_W bits are the index, the rest the tag |
| cpu_ready | output | 1 | Request completed this cycle |
| bus_req | output | 1 | A bus transaction is wanted |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W | Line address of the wanted transaction |
| bus_gnt | input | 1 | The wanted transaction takes place this cycle |
| bus_shared_in | input | 1 | Combined shared line from the other caches, sampled at grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds a valid copy of the snooped line |
| snp_dirty | output | 1 | This cache holds the snooped line modified |

## Verification
A snooped transaction and a processor request can land in the same cycle, even on the same line. The bench provokes this with a store hit on an exclusive-clean line while a read-for-ownership to that line is snooped, and judges it by `cpu_ready` staying low, by the flags of the snoop, and by a read-for-ownership request in the following cycle. A second collision lands a snooped upgrade on a shared line whose own upgrade is still waiting for grant, and the bench expects the pending command to turn into a read-for-ownership. Random mixes of loads, stores and snoops over four tags and four indices produce the other collisions, and a line-state model in the bench predicts every bus request and flag.

// File: rtl/mesi_pkg.sv
// Shared types for the snooping line controller.
// Assumes: the same two-bit command code is used on the request and snoop sides.
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_state_t;

    typedef enum logic [1:0] {
        BC_RD  = 2'd0,
        BC_RDX = 2'd1,
        BC_UPG = 2'd2,
        BC_WB  = 2'd3
    } bus_cmd_t;

endpackage

// File: rtl/mesi_line_array.sv
// Direct-mapped tag and state storage with two read ports (processor, snoop)
// and one write port.
// Assumes: at most one writer per cycle, chosen by the parent.
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 4,
    parameter int TAG_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_a_idx,
    output line_state_t        rd_a_state,
    output logic [TAG_W-1:0]   rd_a_tag,
    input  logic [INDEX_W-1:0] rd_b_idx,
    output line_state_t        rd_b_state,
    output logic [TAG_W-1:0]   rd_b_tag,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  line_state_t        wr_state,
    input  logic [TAG_W-1:0]   wr_tag
);
    localparam int DEPTH = 1 << INDEX_W;

    line_state_t      st_q  [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Hold one entry; cleared to invalid on reset, rewritten on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= LS_I;
                tag_q[g] <= '0;
            end else if (wr_en && (wr_idx == INDEX_W'(g))) begin
                st_q[g]  <= wr_state;
                tag_q[g] <= wr_tag;
            end
        end
    end

    // Asynchronous read for both ports.
    always_comb begin
        rd_a_state = st_q[rd_a_idx];
        rd_a_tag   = tag_q[rd_a_idx];
        rd_b_state = st_q[rd_b_idx];
        rd_b_tag   = tag_q[rd_b_idx];
    end

endmodule

// File: rtl/mesi_cpu_side.sv
// Processor-side decision: picks local completion or a bus transaction from the
// live line state, and produces the line update when the request is served.
// Assumes: the request is held stable until cpu_ready; a grant is atomic.
module mesi_cpu_side
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 4,
    parameter int TAG_W   = 12
) (
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [TAG_W-1:0]         cpu_tag,
    input  logic [INDEX_W-1:0]       cpu_idx,
    input  line_state_t              line_state,
    input  logic [TAG_W-1:0]         line_tag,
    input  logic                     bus_gnt,
    input  logic                     bus_shared_in,
    input  logic                     snp_valid,
    output logic                     cpu_ready,
    output logic                     bus_req,
    output bus_cmd_t                 bus_cmd,
    output logic [TAG_W+INDEX_W-1:0] bus_addr,
    output logic                     upd_en,
    output line_state_t              upd_state,
    output logic [TAG_W-1:0]         upd_tag
);
    logic hit;
    logic need_bus;
    logic served;

    assign hit = (line_state != LS_I) && (line_tag == cpu_tag);

    // Choose between local completion and the bus command to request.
    always_comb begin
        need_bus = 1'b0;
        bus_cmd  = BC_RD;
        bus_addr = {cpu_tag, cpu_idx};
        if (hit) begin
            if (cpu_we && (line_state == LS_S)) begin
                need_bus = 1'b1;
                bus_cmd  = BC_UPG;
            end
        end else if (line_state == LS_M) begin
            need_bus = 1'b1;
            bus_cmd  = BC_WB;
            bus_addr = {line_tag, cpu_idx};
        end else begin
            need_bus = 1'b1;
            bus_cmd  = cpu_we ? BC_RDX : BC_RD;
        end
    end

    assign bus_req   = cpu_req && need_bus;
    assign served    = cpu_req && !snp_valid && (!need_bus || bus_gnt);
    assign cpu_ready = served && !(need_bus && (bus_cmd == BC_WB));
    assign upd_en    = served;

    // Line contents after the served request or transaction.
    always_comb begin
        upd_tag   = cpu_tag;
        upd_state = line_state;
        if (!need_bus) begin
            if (cpu_we) upd_state = LS_M;
        end else begin
            unique case (bus_cmd)
                BC_RD:  upd_state = bus_shared_in ? LS_S : LS_E;
                BC_RDX: upd_state = LS_M;
                BC_UPG: upd_state = LS_M;
                BC_WB: begin
                    upd_state = LS_I;
                    upd_tag   = line_tag;
                end
            endcase
        end
    end

endmodule

// File: rtl/mesi_snoop_side.sv
// Snoop-side decision: reports presence and dirtiness of the snooped line and
// computes its demotion or invalidation.
// Assumes: snooped transactions are atomic and take effect in their own cycle.
module mesi_snoop_side
    import mesi_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             snp_valid,
    input  bus_cmd_t         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_state_t      line_state,
    input  logic [TAG_W-1:0] line_tag,
    output logic             snp_shared,
    output logic             snp_dirty,
    output logic             upd_en,
    output line_state_t      upd_state
);
    logic hit;

    assign hit        = snp_valid && (line_state != LS_I) && (line_tag == snp_tag);
    assign snp_shared = hit;
    assign snp_dirty  = hit && (line_state == LS_M);

    // New state of a matching line for each snooped command.
    always_comb begin
        upd_en    = 1'b0;
        upd_state = line_state;
        if (hit) begin
            unique case (snp_cmd)
                BC_RD: begin
                    upd_en    = 1'b1;
                    upd_state = LS_S;
                end
                BC_RDX, BC_UPG: begin
                    upd_en    = 1'b1;
                    upd_state = LS_I;
                end
                BC_WB: upd_en = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
// Per-cache four-state snooping coherence controller (top).
// Joins the state array, the processor-side and the snoop-side decisions; a
// snoop owns the single write port in its cycle.
// Assumes: bus_gnt is never asserted in a cycle with snp_valid.
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INDEX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_dirty
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] c_idx, s_idx;
    logic [TAG_W-1:0]   c_tag, s_tag;
    line_state_t        c_state, s_state;
    logic [TAG_W-1:0]   c_line_tag, s_line_tag;
    logic               c_upd_en, s_upd_en;
    line_state_t        c_upd_state, s_upd_state;
    logic [TAG_W-1:0]   c_upd_tag;
    bus_cmd_t           c_bus_cmd;
    logic               wr_en;
    logic [INDEX_W-1:0] wr_idx;
    line_state_t        wr_state;
    logic [TAG_W-1:0]   wr_tag;

    assign c_idx = cpu_addr[INDEX_W-1:0];
    assign c_tag = cpu_addr[ADDR_W-1:INDEX_W];
    assign s_idx = snp_addr[INDEX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:INDEX_W];

    mesi_line_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (c_idx),
        .rd_a_state (c_state),
        .rd_a_tag   (c_line_tag),
        .rd_b_idx   (s_idx),
        .rd_b_state (s_state),
        .rd_b_tag   (s_line_tag),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_state   (wr_state),
        .wr_tag     (wr_tag)
    );

    mesi_cpu_side #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_cpu (
        .cpu_req       (cpu_req),
        .cpu_we        (cpu_we),
        .cpu_tag       (c_tag),
        .cpu_idx       (c_idx),
        .line_state    (c_state),
        .line_tag      (c_line_tag),
        .bus_gnt       (bus_gnt),
        .bus_shared_in (bus_shared_in),
        .snp_valid     (snp_valid),
        .cpu_ready     (cpu_ready),
        .bus_req       (bus_req),
        .bus_cmd       (c_bus_cmd),
        .bus_addr      (bus_addr),
        .upd_en        (c_upd_en),
        .upd_state     (c_upd_state),
        .upd_tag       (c_upd_tag)
    );

    mesi_snoop_side #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (bus_cmd_t'(snp_cmd)),
        .snp_tag    (s_tag),
        .line_state (s_state),
        .line_tag   (s_line_tag),
        .snp_shared (snp_shared),
        .snp_dirty  (snp_dirty),
        .upd_en     (s_upd_en),
        .upd_state  (s_upd_state)
    );

    assign bus_cmd = c_bus_cmd;

    // Single write port: a snoop update wins, otherwise the processor update.
    always_comb begin
        wr_en    = s_upd_en || c_upd_en;
        wr_idx   = c_idx;
        wr_state = c_upd_state;
        wr_tag   = c_upd_tag;
        if (s_upd_en) begin
            wr_idx   = s_idx;
            wr_state = s_upd_state;
            wr_tag   = s_line_tag;
        end
    end

    // R11: a grant never shares a cycle with a snoop, and a snoop blocks completion.
    assert_gnt_outside_snoop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_gnt && snp_valid));
    assert_snoop_blocks_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !cpu_ready);

    // R2: after a read fill, the same held load hits without the bus.
    assert_fill_then_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_cmd == BC_RD && !cpu_we) ##1
        (cpu_req && !cpu_we && $stable(cpu_addr)) |-> !bus_req);

    // R4: a completed store leaves the line writable without the bus.
    assert_silent_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) ##1 (cpu_req && cpu_we && $stable(cpu_addr) && !snp_valid)
        |-> (!bus_req && cpu_ready));

    // R5: an upgrade grant completes the store.
    assert_upgrade_completes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_cmd == BC_UPG) |-> cpu_ready);

    // R7: a snooped read leaves no dirty copy behind.
    assert_read_snoop_cleans_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == BC_RD) ##1 (snp_valid && $stable(snp_addr)) |-> !snp_dirty);

    // R8: a snooped ownership request leaves no copy behind.
    assert_own_snoop_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_cmd == BC_RDX || snp_cmd == BC_UPG)) ##1
        (snp_valid && $stable(snp_addr)) |-> !snp_shared);

    // R9: a snooped write-back changes nothing.
    assert_wb_snoop_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd == BC_WB && !cpu_req) ##1 (snp_valid && $stable(snp_addr))
        |-> (snp_shared == $past(snp_shared) && snp_dirty == $past(snp_dirty)));

    // R10: a victim write-back does not complete the request, and the fill follows.
    assert_wb_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_cmd == BC_WB) |-> !cpu_ready);
    assert_wb_then_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && bus_req && bus_cmd == BC_WB) ##1 (cpu_req && $stable(cpu_addr))
        |-> (bus_cmd != BC_WB));

endmodule

// File: tb/mesi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb_top;

    localparam int ADDR_W  = 16;
    localparam int INDEX_W = 4;
    localparam int DEPTH   = 1 << INDEX_W;
    localparam int A_RD = 0, A_RDX = 1, A_UPG = 2, A_WB = 3, A_DONE = 4;
    localparam int S_I = 0, S_S = 1, S_E = 2, S_M = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_req, cpu_we;
    logic [ADDR_W-1:0] cpu_addr;
    logic              cpu_ready;
    logic              bus_req;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_gnt, bus_shared_in;
    logic              snp_valid;
    logic [1:0]        snp_cmd;
    logic [ADDR_W-1:0] snp_addr;
    logic              snp_shared, snp_dirty;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    int exp_st  [DEPTH];
    int exp_tag [DEPTH];

    always #2.5 clk = ~clk;

    mesi_snoop_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_dirty(snp_dirty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int idx_of(input int a);
        return a % DEPTH;
    endfunction

    function automatic int tag_of(input int a);
        return a / DEPTH;
    endfunction

    function automatic bit hit_of(input int a);
        return exp_st[idx_of(a)] != S_I && exp_tag[idx_of(a)] == tag_of(a);
    endfunction

    // Expected action for a request, from R2..R5 and R10.
    function automatic int act_of(input bit we, input int a);
        int i = idx_of(a);
        if (hit_of(a)) return (we && exp_st[i] == S_S) ? A_UPG : A_DONE;
        if (exp_st[i] == S_M) return A_WB;
        return we ? A_RDX : A_RD;
    endfunction

    function automatic string req_of(input int act, input bit we);
        case (act)
            A_RD:   return "R2";
            A_RDX:  return "R3";
            A_UPG:  return "R5";
            A_WB:   return "R10";
            default: return we ? "R4" : "R2";
        endcase
    endfunction

    task automatic model_cpu(input int act, input bit we, input int a, input bit shin);
        int i = idx_of(a);
        case (act)
            A_DONE: if (we) exp_st[i] = S_M;
            A_RD: begin exp_st[i] = shin ? S_S : S_E; exp_tag[i] = tag_of(a); end
            A_RDX, A_UPG: begin exp_st[i] = S_M; exp_tag[i] = tag_of(a); end
            default: exp_st[i] = S_I;
        endcase
    endtask

    task automatic model_snoop(input int cmd, input int a);
        int i = idx_of(a);
        if (!hit_of(a)) return;
        if (cmd == 0) exp_st[i] = S_S;
        else if (cmd == 1 || cmd == 2) exp_st[i] = S_I;
    endtask

    // Check one cycle of the request side against the model and grant if needed.
    task automatic cpu_cycle(input bit we, input int a, input bit shin, input bit grant,
                             output int act);
        int i = idx_of(a);
        int exp_addr;
        string r;
        act = act_of(we, a);
        r = req_of(act, we);
        exp_addr = (act == A_WB) ? (exp_tag[i] * DEPTH + i) : a;
        if (act == A_DONE) begin
            chk(cpu_ready == 1'b1 && bus_req == 1'b0, r, "local completion",
                int'({cpu_ready, bus_req}), 2);
            model_cpu(act, we, a, shin);
        end else begin
            chk(bus_req == 1'b1 && int'(bus_cmd) == act, r, "bus command",
                int'({bus_req, bus_cmd}), 4 + act);
            chk(int'(bus_addr) == exp_addr, r, "bus address", int'(bus_addr), exp_addr);
            if (grant) begin
                bus_gnt = 1'b1;
                #1;
                chk(cpu_ready == (act != A_WB), r, "ready at grant",
                    int'(cpu_ready), int'(act != A_WB));
                model_cpu(act, we, a, shin);
            end else begin
                chk(cpu_ready == 1'b0, r, "stall before grant", int'(cpu_ready), 0);
            end
        end
    endtask

    // Full processor access with an optional grant delay.
    task automatic access(input bit we, input int a, input bit shin, input int gdelay);
        int act;
        int waited = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(a);
            bus_gnt = 1'b0; bus_shared_in = shin; snp_valid = 1'b0;
            #1;
            cpu_cycle(we, a, shin, waited >= gdelay, act);
            if (act != A_DONE && waited < gdelay) begin
                waited++;
                continue;
            end
            waited = 0;
            if (act != A_WB) break;
        end
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0;
    endtask

    task automatic snoop(input int cmd, input int a);
        int i = idx_of(a);
        bit esh, edt;
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0;
        snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = ADDR_W'(a);
        #1;
        esh = hit_of(a);
        edt = esh && exp_st[i] == S_M;
        chk(snp_shared == esh, "R6", "snoop shared flag", int'(snp_shared), int'(esh));
        chk(snp_dirty == edt, "R6", "snoop dirty flag", int'(snp_dirty), int'(edt));
        model_snoop(cmd, a);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // Probe a line with a snooped write-back (R9: no effect) and compare the state.
    task automatic probe(input int a, input int exp_state, input string r);
        @(negedge clk);
        cpu_req = 1'b0;
        snp_valid = 1'b1; snp_cmd = 2'd3; snp_addr = ADDR_W'(a);
        #1;
        chk(snp_shared == (exp_state != S_I) && snp_dirty == (exp_state == S_M), r,
            "line state probe", int'({snp_shared, snp_dirty}),
            int'({exp_state != S_I, exp_state == S_M}));
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int act;
        for (int i = 0; i < DEPTH; i++) begin exp_st[i] = S_I; exp_tag[i] = 0; end
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0;
        bus_gnt = 1'b0; bus_shared_in = 1'b0;
        snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all invalid
        probe(16'h0011, S_I, "R1");
        probe(16'h0000, S_I, "R1");
        access(1'b0, 16'h0011, 1'b0, 0);           // R2 fill exclusive-clean
        probe(16'h0011, S_E, "R2");
        access(1'b1, 16'h0011, 1'b0, 0);           // R4 silent store
        probe(16'h0011, S_M, "R4");
        probe(16'h0011, S_M, "R9");                // R9 write-back snoop inert
        snoop(0, 16'h0011);                        // R7 demote, dirty flag
        probe(16'h0011, S_S, "R7");
        access(1'b1, 16'h0011, 1'b0, 1);           // R5 upgrade with delayed grant
        probe(16'h0011, S_M, "R5");
        access(1'b0, 16'h0011, 1'b0, 0);           // R2 load hit

        access(1'b0, 16'h0022, 1'b1, 0);           // R2 fill shared
        probe(16'h0022, S_S, "R2");
        snoop(1, 16'h0022);                        // R8 invalidate
        probe(16'h0022, S_I, "R8");
        access(1'b1, 16'h0033, 1'b0, 0);           // R3 store miss
        probe(16'h0033, S_M, "R3");
        snoop(2, 16'h0133);                        // R6 tag mismatch: no flags
        access(1'b0, 16'h0133, 1'b1, 0);           // R10 write-back then fill
        probe(16'h0033, S_I, "R10");
        probe(16'h0133, S_S, "R10");
        access(1'b0, 16'h0044, 1'b0, 0);
        access(1'b0, 16'h0144, 1'b0, 0);           // R10 silent eviction of E
        probe(16'h0144, S_E, "R10");

        // R11: store hit on E collides with a snooped read-for-ownership
        access(1'b0, 16'h0055, 1'b0, 0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h0055;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 16'h0055;
        #1;
        chk(cpu_ready == 1'b0, "R11", "ready during snoop", int'(cpu_ready), 0);
        chk(snp_shared && !snp_dirty, "R11", "flags during collision",
            int'({snp_shared, snp_dirty}), 2);
        model_snoop(1, 16'h0055);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(bus_req && bus_cmd == 2'd1, "R11", "request re-evaluated as ownership",
            int'({bus_req, bus_cmd}), 5);
        cpu_cycle(1'b1, 16'h0055, 1'b0, 1'b1, act);
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0;
        probe(16'h0055, S_M, "R11");

        // R12: pending upgrade overtaken by a snooped upgrade
        access(1'b0, 16'h0088, 1'b1, 0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h0088;
        #1;
        chk(bus_req && bus_cmd == 2'd2, "R12", "upgrade pending",
            int'({bus_req, bus_cmd}), 6);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 16'h0088;
        #1;
        chk(cpu_ready == 1'b0 && snp_shared, "R12", "snoop while pending",
            int'({cpu_ready, snp_shared}), 1);
        model_snoop(2, 16'h0088);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(bus_req && bus_cmd == 2'd1, "R12", "pending became ownership",
            int'({bus_req, bus_cmd}), 5);
        cpu_cycle(1'b1, 16'h0088, 1'b0, 1'b1, act);
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0;

        // Random mix over four tags and four indices
        void'($urandom(32'h1d5e_ed01));
        for (int n = 0; n < 400; n++) begin
            int a = int'(($urandom % 4) * DEPTH + ($urandom % 4));
            int op = int'($urandom % 3);
            if (op == 2) snoop(int'($urandom % 4), a);
            else access(op == 1, a, bit'($urandom % 2), int'($urandom % 3));
        end

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule